// File: doc/BRIEF.md
# PWM Audio Playback Engine with Sample Ring

This block turns a stream of 8-bit mono audio bytes into a one-bit pulse-width modulated pin. A bus engine hands bytes in through a simple valid/data write port. The bytes are queued in a circular RAM buffer, with separate write and read pointers. A free-running divider produces a sample-rate tick near 44.1 kHz from the 50 MHz system clock. On each tick the oldest queued byte becomes the current sample. If nothing is queued, the previous sample is kept, so an underrun holds a steady level instead of producing noise.

A second, independent counter forms the PWM carrier: 9 bits wide, free-running, with a period of 512 clocks (about 97.7 kHz). The current sample is copied into a compare register only on the last count of a carrier period, so every carrier period uses exactly one duty value. The pin is high while the carrier count is below the compare value times two. A full flag tells the bus engine to stall. A write offered while the buffer is full is dropped.

Top module: `pwm_audio_player`

## Requirements
- R1: A write with `wr_valid` high and `full` low stores `wr_data` at the tail of the buffer on that clock edge, and bytes leave the buffer in the order they were written. A write and a read on the same edge both take effect.
- R2: `full` is high exactly when the buffer holds 2^DEPTH_LOG2 entries. A write offered while `full` is high is discarded and never reaches the output.
- R3: The sample tick fires on every TICK_DIV-th clock edge. The first tick is the edge with index TICK_DIV-1, counting from 0 at the first edge after reset is released.
- R4: On a tick with a non-empty buffer, the oldest byte becomes the current sample. On a tick with an empty buffer, the current sample keeps its value.
- R5: The carrier count is 0 when reset is released, rises by one on every edge, and wraps from 2^CARRIER_W-1 (511) to 0.
- R6: The compare register takes the current sample only on the edge where the carrier count is at its maximum. A sample change in the middle of a period leaves that period's duty unchanged.
- R7: `pwm_out` is high while the carrier count is below the compare value shifted left by CARRIER_W-8 bits (one bit by default). Each full period is therefore high for 2*sample clocks: a sample of 0 is always low, and 255 is high for 510 of 512 clocks.
- R8: While `rst_n` is low, the buffer is empty, the current sample and compare value are 0, `pwm_out` is low and `full` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Offer of one audio byte this cycle |
| wr_data | input | SAMPLE_W | Audio byte, unsigned |
| full | output | 1 | Buffer full; writes are dropped while high |
| pwm_out | output | 1 | One-bit PWM audio output |

## Verification
A write changes `full` on the same clock edge that stores it. A tick changes the current sample on the edge with index TICK_DIV-1 (mod TICK_DIV). That sample shows on the pin only in the carrier period that begins after the next wrap edge, so the first duty change lags its tick by up to 512 clocks. The bench keeps its own edge counter and replays each edge in order: compare load first, then the tick pop, then the write push. It then samples the pin half a cycle later and compares the count of high clocks in each full carrier period with twice the sample it expects for that period.

// File: rtl/pwm_audio_pkg.sv
package pwm_audio_pkg;
  localparam int unsigned DEF_SAMPLE_W   = 8;
  localparam int unsigned DEF_DEPTH_LOG2 = 8;
  localparam int unsigned DEF_CARRIER_W  = 9;
  localparam int unsigned DEF_TICK_DIV   = 1134;
endpackage

// File: rtl/pwm_rate_divider.sv
module pwm_rate_divider #(
  parameter int unsigned DIV = 1134
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_sample_ring.sv
module pwm_sample_ring #(
  parameter int unsigned SAMPLE_W   = 8,
  parameter int unsigned DEPTH_LOG2 = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SAMPLE_W-1:0]   wr_byte,
  input  logic                  rd_en,
  output logic [SAMPLE_W-1:0]   rd_byte,
  output logic                  full,
  output logic                  empty,
  output logic [DEPTH_LOG2:0]   level
);
  localparam int unsigned DEPTH = 1 << DEPTH_LOG2;

  logic [SAMPLE_W-1:0]   mem [DEPTH];
  logic [DEPTH_LOG2-1:0] wr_ptr_q, rd_ptr_q;
  logic [DEPTH_LOG2:0]   level_q;
  logic                  push, pop;

  assign full    = (level_q == (DEPTH_LOG2+1)'(DEPTH));
  assign empty   = (level_q == '0);
  assign push    = wr_en && !full;
  assign pop     = rd_en && !empty;
  assign rd_byte = mem[rd_ptr_q];
  assign level   = level_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push, pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end
endmodule

// File: rtl/pwm_compare_out.sv
module pwm_compare_out #(
  parameter int unsigned SAMPLE_W  = 8,
  parameter int unsigned CARRIER_W = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SAMPLE_W-1:0]  sample_in,
  output logic                 wrap,
  output logic [CARRIER_W-1:0] carrier,
  output logic [SAMPLE_W-1:0]  cmp,
  output logic                 pwm_out
);
  localparam int unsigned SHIFT = CARRIER_W - SAMPLE_W;

  function automatic logic [CARRIER_W-1:0] duty_threshold(input logic [SAMPLE_W-1:0] s);
    return CARRIER_W'(s) << SHIFT;
  endfunction

  logic [CARRIER_W-1:0] carrier_q;
  logic [SAMPLE_W-1:0]  cmp_q;

  assign wrap    = &carrier_q;
  assign carrier = carrier_q;
  assign cmp     = cmp_q;
  assign pwm_out = (carrier_q < duty_threshold(cmp_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carrier_q <= '0;
      cmp_q     <= '0;
    end else begin
      carrier_q <= carrier_q + 1'b1;
      if (wrap) cmp_q <= sample_in;
    end
  end
endmodule

// File: rtl/pwm_audio_player.sv
module pwm_audio_player
  import pwm_audio_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = DEF_SAMPLE_W,
  parameter int unsigned DEPTH_LOG2 = DEF_DEPTH_LOG2,
  parameter int unsigned CARRIER_W  = DEF_CARRIER_W,
  parameter int unsigned TICK_DIV   = DEF_TICK_DIV
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [SAMPLE_W-1:0] wr_data,
  output logic                full,
  output logic                pwm_out
);
  // Named internal events, observed by the bound checker
  logic                 sample_tick;
  logic                 carrier_wrap;
  logic [CARRIER_W-1:0] carrier_cnt;
  logic [SAMPLE_W-1:0]  cmp_sample;
  logic [SAMPLE_W-1:0]  cur_sample;
  logic [SAMPLE_W-1:0]  head_byte;
  logic                 ring_empty;
  logic [DEPTH_LOG2:0]  fill_level;

  pwm_rate_divider #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (sample_tick)
  );

  pwm_sample_ring #(.SAMPLE_W(SAMPLE_W), .DEPTH_LOG2(DEPTH_LOG2)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_valid),
    .wr_byte(wr_data),
    .rd_en  (sample_tick),
    .rd_byte(head_byte),
    .full   (full),
    .empty  (ring_empty),
    .level  (fill_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                         cur_sample <= '0;
    else if (sample_tick && !ring_empty) cur_sample <= head_byte;
  end

  pwm_compare_out #(.SAMPLE_W(SAMPLE_W), .CARRIER_W(CARRIER_W)) u_pwm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_in(cur_sample),
    .wrap     (carrier_wrap),
    .carrier  (carrier_cnt),
    .cmp      (cmp_sample),
    .pwm_out  (pwm_out)
  );
endmodule

// File: rtl/pwm_audio_checker.sv
module pwm_audio_checker #(
  parameter int unsigned SAMPLE_W   = 8,
  parameter int unsigned DEPTH_LOG2 = 8,
  parameter int unsigned CARRIER_W  = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_valid,
  input logic                 full,
  input logic                 pwm_out,
  input logic                 sample_tick,
  input logic                 carrier_wrap,
  input logic [CARRIER_W-1:0] carrier_cnt,
  input logic [SAMPLE_W-1:0]  cmp_sample,
  input logic [SAMPLE_W-1:0]  cur_sample,
  input logic                 ring_empty,
  input logic [DEPTH_LOG2:0]  fill_level
);
  localparam int unsigned DEPTH = 1 << DEPTH_LOG2;

  a_r1_accept_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !full && !sample_tick) |=> (fill_level == $past(fill_level) + 1'b1));

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_valid && !sample_tick) |=> (fill_level == (DEPTH_LOG2+1)'(DEPTH)));

  a_r3_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);

  a_r4_hold_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && ring_empty) |=> $stable(cur_sample));

  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_wrap |=> (carrier_cnt == '0));

  a_r6_load_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_sample != $past(cmp_sample)) |-> $past(carrier_wrap));

  a_r7_zero_is_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_sample == '0) |-> !pwm_out);

  a_r7_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_sample != '0 && carrier_cnt == '0) |-> pwm_out);
endmodule

bind pwm_audio_player pwm_audio_checker #(
  .SAMPLE_W  (SAMPLE_W),
  .DEPTH_LOG2(DEPTH_LOG2),
  .CARRIER_W (CARRIER_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .full        (full),
  .pwm_out     (pwm_out),
  .sample_tick (sample_tick),
  .carrier_wrap(carrier_wrap),
  .carrier_cnt (carrier_cnt),
  .cmp_sample  (cmp_sample),
  .cur_sample  (cur_sample),
  .ring_empty  (ring_empty),
  .fill_level  (fill_level)
);

// File: tb/sim_pwm_audio_player.sv
module sim_pwm_audio_player;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH_LOG2 = 3;
  localparam int DEPTH      = 1 << DEPTH_LOG2;
  localparam int TICK       = 1134;
  localparam int PERIOD     = 512;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_valid;
  logic [7:0] wr_data;
  logic       full;
  logic       pwm_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_audio_player #(.DEPTH_LOG2(DEPTH_LOG2), .TICK_DIV(TICK)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .full(full), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard state
  logic [7:0] exp_q[$];
  int  edges = 0;
  int  k = 0;
  int  cur_m = 0;
  int  cmp_m = 0;
  int  hi_cnt = 0;
  bit  have_start = 0;
  bit  last_v = 0;
  logic [7:0] last_d = '0;

  always @(posedge clk) if (rst_n === 1'b1) edges++;

  // Driver: offers one byte; the expected copy is pushed by the monitor
  task automatic write_sample(input logic [7:0] v);
    @(posedge clk); #2;
    wr_valid = 1'b1; wr_data = v;
    @(posedge clk); #2;
    wr_valid = 1'b0;
  endtask

  // Monitor: replays each edge (R5 R6 compare load, R3 R4 tick pop, R1 R2 push),
  // then checks the pin duty for each complete carrier period (R7).
  always @(negedge clk) begin
    if (rst_n === 1'b1 && k < edges) begin
      int sz0;
      int car;
      sz0 = exp_q.size();
      if (k % PERIOD == PERIOD - 1) cmp_m = cur_m;
      if (k % TICK == TICK - 1 && exp_q.size() > 0) cur_m = exp_q.pop_front();
      if (last_v) begin
        if (sz0 < DEPTH) exp_q.push_back(last_d);
        check(full == (exp_q.size() == DEPTH), "R1 R2 full flag", full, exp_q.size() == DEPTH);
      end
      k++;
      car = k % PERIOD;
      if (car == 0) begin
        hi_cnt = 0;
        have_start = 1;
      end
      hi_cnt += pwm_out;
      if (car == PERIOD - 1 && have_start)
        check(hi_cnt == 2 * cmp_m, "R3 R4 R5 R6 R7 period duty", hi_cnt, 2 * cmp_m);
    end
    last_v = wr_valid;
    last_d = wr_data;
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0;
    repeat (4) @(negedge clk);
    check(pwm_out == 1'b0, "R8 reset pwm low", pwm_out, 0);
    check(full == 1'b0, "R8 reset not full", full, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    // Fill all entries before the first tick: extremes and mid values
    write_sample(8'd0);
    write_sample(8'd255);
    write_sample(8'd128);
    write_sample(8'd1);
    write_sample(8'd64);
    write_sample(8'd200);
    write_sample(8'd17);
    write_sample(8'd90);
    // R2: write into a full buffer is dropped; later durations show it never plays
    write_sample(8'd238);
    write_sample(8'd77);
    // Drain, then underrun hold for several ticks (R4)
    repeat (TICK * 12) @(posedge clk);
    // Sparse writes at arbitrary carrier phases (R6)
    repeat (300) @(posedge clk);
    write_sample(8'd33);
    repeat (TICK + 155) @(posedge clk);
    write_sample(8'd250);
    write_sample(8'd5);
    repeat (TICK * 4) @(posedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule